// File: doc/BRIEF.md
# Paired Store-Exclusive Execution Unit

This unit executes a paired store-exclusive with release inside a load/store pipeline. Each request carries a decoded instruction: an element-size bit and four register indices (status, first data, second data, base). It also carries the register-file values it needs and the current stack pointer. The unit resolves register-overlap hazards under a selectable policy and picks the base from the stack pointer or a general register. It checks alignment and tests a local exclusive monitor. It then either issues one atomic write of the two packed elements or suppresses it.

Every request produces a result exactly one cycle later, whatever its data or outcome. That result holds a fault code, an optional memory write, and an optional status writeback whose 32-bit value is 0 when memory was updated and 1 when it was not. A load-exclusive elsewhere in the pipeline arms the monitor through a plain arm port that carries an address and a size.

Top module: `stxp_unit`

## Requirements
- R1: With `req_wide`=0 each element is the low 32 bits of its register, the write is 64 bits (`wr_wide`=0) and `wr_data[127:64]` is zero. With `req_wide`=1 each element is the full 64-bit register and the write is 128 bits (`wr_wide`=1).
- R2: A status writeback raises `st_wen` and sets `st_idx` to the status index. `st_data` is the status bit zero-extended to 32 bits.
- R3: When the monitor check passes, `wr_en` pulses for one cycle and the status value is 0.
- R4: With `big_endian`=0 the second register's element fills the upper half of the write and the first register's element the lower half. With `big_endian`=1 the order is reversed.
- R5: Base index 31 selects `sp_val`; any other index selects `rn_val`. With base index 31 and `sp_val` not a multiple of 16, `fault`=3 is reported, with no write and no status writeback.
- R6: If the status index equals either data index, `ovl_policy` decides the outcome. Policy 0 writes the parameter `ARB_DATA` (its low 64 bits for the 32-bit size) and proceeds normally. Policy 1 gives `fault`=1 with no write and no status. Policies 2 and 3 make the request a no-op: `fault`=0, no write, no status, and the monitor is left unchanged.
- R7: If the status index equals the base index and the base index is not 31, the same policy applies. Under policy 0 the address becomes the parameter `ARB_ADDR`.
- R8: An address that is not a multiple of the access size (8 bytes for 32-bit elements, 16 for 64-bit) gives `fault`=2, with no write and no status. This holds even when the monitor would fail, and the monitor is left unchanged.
- R9: The monitor passes only when it is valid and both its address and its size equal the request's. Otherwise the status is 1 and no write occurs.
- R10: Reset clears the monitor. `arm_valid` sets it. Any request that reaches the status writeback clears it. An arm in the same cycle as such a request wins, and that request is checked against the earlier state.
- R11: `res_valid` follows each `req_valid` by exactly one cycle for every outcome, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_valid | input | 1 | Arm the exclusive monitor |
| arm_addr | input | AW | Address tagged by the arm |
| arm_wide | input | 1 | Size tagged by the arm (1 = 128-bit) |
| req_valid | input | 1 | Request issue |
| req_wide | input | 1 | Element size bit (0 = 32-bit, 1 = 64-bit) |
| req_rs | input | 5 | Status register index |
| req_rt | input | 5 | First data register index |
| req_rt2 | input | 5 | Second data register index |
| req_rn | input | 5 | Base register index (31 = stack pointer) |
| rt_val | input | XW | First data register value |
| rt2_val | input | XW | Second data register value |
| rn_val | input | AW | Base register value |
| sp_val | input | AW | Stack pointer value |
| big_endian | input | 1 | Data endianness for the access |
| ovl_policy | input | 2 | Overlap policy: 0 arbitrary, 1 undefined, 2/3 no-op |
| res_valid | output | 1 | Result valid |
| fault | output | 2 | 0 none, 1 undefined, 2 alignment, 3 stack alignment |
| wr_en | output | 1 | Atomic memory write strobe |
| wr_wide | output | 1 | Write size (1 = 128-bit) |
| wr_addr | output | AW | Write address |
| wr_data | output | 2*XW | Write data |
| st_wen | output | 1 | Status writeback enable |
| st_idx | output | 5 | Status destination index |
| st_data | output | 32 | Zero-extended status value |

## Verification
The bench keeps the default 64-bit address and register widths and overrides `ARB_DATA` with a pattern that differs in every byte from both data registers. It also sets `ARB_ADDR` to an aligned address that no request supplies directly. With these values, a write under the arbitrary policy can only match the expected value if the substitution really happened. The arbitrary-address case is armed at that address, so it reaches a successful write, and the exact address it lands on becomes visible.

// File: rtl/stxp_pkg.sv
package stxp_pkg;

    typedef enum logic [1:0] {
        POL_ARB     = 2'd0,
        POL_UNDEF   = 2'd1,
        POL_NOP     = 2'd2,
        POL_NOP_ALT = 2'd3
    } ovl_policy_e;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_UNDEF    = 2'd1,
        FLT_ALIGN    = 2'd2,
        FLT_SP_ALIGN = 2'd3
    } flt_e;

    typedef struct packed {
        logic undef;
        logic skip;
        logic arb_data;
        logic arb_addr;
    } hazard_t;

    localparam logic [4:0] SP_IDX = 5'd31;

    // low address bits against the access size: 8 bytes or 16 bytes
    function automatic logic misaligned(input logic wide, input logic [3:0] low);
        return wide ? (low != 4'd0) : (low[2:0] != 3'd0);
    endfunction

endpackage

// File: rtl/stxp_hazard.sv
module stxp_hazard
    import stxp_pkg::*;
(
    input  logic [4:0] rs,
    input  logic [4:0] rt,
    input  logic [4:0] rt2,
    input  logic [4:0] rn,
    input  logic [1:0] policy,
    output hazard_t    haz
);
    logic data_ovl;
    logic base_ovl;

    assign data_ovl = (rs == rt) || (rs == rt2);
    assign base_ovl = (rs == rn) && (rn != SP_IDX);

    always_comb begin
        haz = '0;
        unique case (ovl_policy_e'(policy))
            POL_ARB: begin
                haz.arb_data = data_ovl;
                haz.arb_addr = base_ovl;
            end
            POL_UNDEF: haz.undef = data_ovl | base_ovl;
            default:   haz.skip  = data_ovl | base_ovl;
        endcase
    end
endmodule

// File: rtl/stxp_monitor.sv
module stxp_monitor #(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm_valid,
    input  logic [AW-1:0] arm_addr,
    input  logic          arm_wide,
    input  logic [AW-1:0] chk_addr,
    input  logic          chk_wide,
    input  logic          consume,
    output logic          pass
);
    logic          armed_q;
    logic [AW-1:0] tag_addr_q;
    logic          tag_wide_q;

    assign pass = armed_q && (tag_addr_q == chk_addr) && (tag_wide_q == chk_wide);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q    <= 1'b0;
            tag_addr_q <= '0;
            tag_wide_q <= 1'b0;
        end else if (arm_valid) begin
            armed_q    <= 1'b1;
            tag_addr_q <= arm_addr;
            tag_wide_q <= arm_wide;
        end else if (consume) begin
            armed_q    <= 1'b0;
        end
    end
endmodule

// File: rtl/stxp_pack.sv
module stxp_pack #(
    parameter int              XW       = 64,
    parameter logic [2*XW-1:0] ARB_DATA = '0
) (
    input  logic            wide,
    input  logic            be,
    input  logic            arb_en,
    input  logic [XW-1:0]   first,
    input  logic [XW-1:0]   second,
    output logic [2*XW-1:0] data
);
    localparam int HW = XW / 2;
    localparam int DW = 2 * XW;

    logic [XW-1:0] narrow_pair;
    logic [DW-1:0] wide_pair;

    // two size variants built side by side, the size bit picks one
    for (genvar g = 0; g < 2; g++) begin : g_var
        if (g == 0) begin : g_narrow
            assign narrow_pair = be ? {first[HW-1:0], second[HW-1:0]}
                                    : {second[HW-1:0], first[HW-1:0]};
        end else begin : g_wide
            assign wide_pair = be ? {first, second} : {second, first};
        end
    end

    always_comb begin
        if (arb_en)
            data = wide ? ARB_DATA : {{XW{1'b0}}, ARB_DATA[XW-1:0]};
        else
            data = wide ? wide_pair : {{XW{1'b0}}, narrow_pair};
    end
endmodule

// File: rtl/stxp_unit.sv
module stxp_unit
    import stxp_pkg::*;
#(
    parameter int              AW       = 64,
    parameter int              XW       = 64,
    parameter logic [2*XW-1:0] ARB_DATA = '0,
    parameter logic [AW-1:0]   ARB_ADDR = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            arm_valid,
    input  logic [AW-1:0]   arm_addr,
    input  logic            arm_wide,
    input  logic            req_valid,
    input  logic            req_wide,
    input  logic [4:0]      req_rs,
    input  logic [4:0]      req_rt,
    input  logic [4:0]      req_rt2,
    input  logic [4:0]      req_rn,
    input  logic [XW-1:0]   rt_val,
    input  logic [XW-1:0]   rt2_val,
    input  logic [AW-1:0]   rn_val,
    input  logic [AW-1:0]   sp_val,
    input  logic            big_endian,
    input  logic [1:0]      ovl_policy,
    output logic            res_valid,
    output logic [1:0]      fault,
    output logic            wr_en,
    output logic            wr_wide,
    output logic [AW-1:0]   wr_addr,
    output logic [2*XW-1:0] wr_data,
    output logic            st_wen,
    output logic [4:0]      st_idx,
    output logic [31:0]     st_data
);
    localparam int DW = 2 * XW;

    hazard_t       haz;
    logic [AW-1:0] base;
    logic [AW-1:0] addr;
    logic [DW-1:0] packed_data;
    logic          sp_bad;
    logic          addr_bad;
    logic          proceed;
    logic          mon_pass;
    flt_e          flt_d;

    stxp_hazard u_haz (
        .rs     (req_rs),
        .rt     (req_rt),
        .rt2    (req_rt2),
        .rn     (req_rn),
        .policy (ovl_policy),
        .haz    (haz)
    );

    stxp_pack #(.XW(XW), .ARB_DATA(ARB_DATA)) u_pack (
        .wide   (req_wide),
        .be     (big_endian),
        .arb_en (haz.arb_data),
        .first  (rt_val),
        .second (rt2_val),
        .data   (packed_data)
    );

    assign base     = (req_rn == SP_IDX) ? sp_val : rn_val;
    assign addr     = haz.arb_addr ? ARB_ADDR : base;
    assign sp_bad   = (req_rn == SP_IDX) && (sp_val[3:0] != 4'd0);
    assign addr_bad = misaligned(req_wide, addr[3:0]);
    assign proceed  = req_valid && !haz.undef && !haz.skip && !sp_bad && !addr_bad;

    stxp_monitor #(.AW(AW)) u_mon (
        .clk       (clk),
        .rst       (rst),
        .arm_valid (arm_valid),
        .arm_addr  (arm_addr),
        .arm_wide  (arm_wide),
        .chk_addr  (addr),
        .chk_wide  (req_wide),
        .consume   (proceed),
        .pass      (mon_pass)
    );

    // fault priority: decode hazard, stack alignment, access alignment
    always_comb begin
        if (haz.undef)                flt_d = FLT_UNDEF;
        else if (haz.skip)            flt_d = FLT_NONE;
        else if (sp_bad)              flt_d = FLT_SP_ALIGN;
        else if (addr_bad)            flt_d = FLT_ALIGN;
        else                          flt_d = FLT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            fault     <= FLT_NONE;
            wr_en     <= 1'b0;
            wr_wide   <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            st_wen    <= 1'b0;
            st_idx    <= '0;
            st_data   <= '0;
        end else begin
            res_valid <= req_valid;
            fault     <= req_valid ? flt_d : FLT_NONE;
            wr_en     <= proceed && mon_pass;
            st_wen    <= proceed;
            if (proceed) begin
                wr_wide <= req_wide;
                wr_addr <= addr;
                wr_data <= packed_data;
                st_idx  <= req_rs;
                st_data <= {31'd0, ~mon_pass};
            end
        end
    end
endmodule

// File: rtl/stxp_unit_chk.sv
module stxp_unit_chk #(
    parameter int AW = 64,
    parameter int XW = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            res_valid,
    input logic [1:0]      fault,
    input logic            wr_en,
    input logic            wr_wide,
    input logic [AW-1:0]   wr_addr,
    input logic [2*XW-1:0] wr_data,
    input logic            st_wen,
    input logic [31:0]     st_data
);
    // R2: status value occupies bit 0 only
    a_r2_zero_extend: assert property (@(posedge clk) disable iff (rst)
        st_wen |-> (st_data[31:1] == 31'd0));

    // R3: a write always reports success
    a_r3_write_status_zero: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (st_wen && st_data[0] == 1'b0));

    // R1: narrow writes leave the upper half clear
    a_r1_narrow_upper_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_wide) |-> (wr_data[2*XW-1:XW] == '0));

    // R8: a write never lands on a misaligned address
    a_r8_write_aligned: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_wide ? (wr_addr[3:0] == 4'd0) : (wr_addr[2:0] == 3'd0)));

    // R5/R8: any fault suppresses both write and status
    a_r8_fault_quiet: assert property (@(posedge clk) disable iff (rst)
        (fault != 2'd0) |-> (!wr_en && !st_wen));

    // R11: fixed one-cycle result latency
    a_r11_result_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!res_valid && !wr_en && !st_wen));
endmodule

bind stxp_unit stxp_unit_chk #(.AW(AW), .XW(XW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .res_valid (res_valid),
    .fault     (fault),
    .wr_en     (wr_en),
    .wr_wide   (wr_wide),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .st_wen    (st_wen),
    .st_data   (st_data)
);

// File: tb/tb_stxp_unit.sv
module tb_stxp_unit;
    localparam int AW = 64;
    localparam int XW = 64;
    localparam logic [127:0] ARB_D = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
    localparam logic [63:0]  ARB_A = 64'h5000;
    localparam logic [63:0]  RT_V  = 64'h1111_2222_3333_4444;
    localparam logic [63:0]  RT2_V = 64'hAAAA_BBBB_CCCC_DDDD;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst, arm_valid, arm_wide, req_valid, req_wide, big_endian;
    logic [AW-1:0]   arm_addr, rn_val, sp_val;
    logic [4:0]      req_rs, req_rt, req_rt2, req_rn;
    logic [1:0]      ovl_policy;
    logic            res_valid, wr_en, wr_wide, st_wen;
    logic [1:0]      fault;
    logic [AW-1:0]   wr_addr;
    logic [2*XW-1:0] wr_data;
    logic [4:0]      st_idx;
    logic [31:0]     st_data;

    stxp_unit #(.AW(AW), .XW(XW), .ARB_DATA(ARB_D), .ARB_ADDR(ARB_A)) dut (
        .clk(clk), .rst(rst), .arm_valid(arm_valid), .arm_addr(arm_addr),
        .arm_wide(arm_wide), .req_valid(req_valid), .req_wide(req_wide),
        .req_rs(req_rs), .req_rt(req_rt), .req_rt2(req_rt2), .req_rn(req_rn),
        .rt_val(RT_V), .rt2_val(RT2_V), .rn_val(rn_val), .sp_val(sp_val),
        .big_endian(big_endian), .ovl_policy(ovl_policy),
        .res_valid(res_valid), .fault(fault), .wr_en(wr_en), .wr_wide(wr_wide),
        .wr_addr(wr_addr), .wr_data(wr_data), .st_wen(st_wen), .st_idx(st_idx),
        .st_data(st_data)
    );

    typedef struct packed {
        logic        arm;
        logic        arm_sz;
        logic [31:0] arm_a;
        logic        sz;
        logic        be;
        logic [1:0]  pol;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  rt2;
        logic [4:0]  rn;
        logic [31:0] base;
        logic [31:0] sp;
        logic        e_wr;
        logic        e_st;
        logic        e_stat;
        logic [1:0]  e_flt;
        logic        e_arb;
        logic [31:0] e_addr;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,32'h1000, 1'b1,1'b0,2'd0, 5'd1,5'd2,5'd3,5'd4,  32'h1000,32'h8000, 1'b1,1'b1,1'b0,2'd0,1'b0,32'h1000},
        '{1'b0,1'b0,32'h0,    1'b1,1'b0,2'd0, 5'd1,5'd2,5'd3,5'd4,  32'h1000,32'h8000, 1'b0,1'b1,1'b1,2'd0,1'b0,32'h1000},
        '{1'b1,1'b0,32'h2000, 1'b0,1'b1,2'd0, 5'd1,5'd2,5'd3,5'd4,  32'h2000,32'h8000, 1'b1,1'b1,1'b0,2'd0,1'b0,32'h2000},
        '{1'b1,1'b0,32'h2000, 1'b1,1'b0,2'd0, 5'd1,5'd2,5'd3,5'd4,  32'h2000,32'h8000, 1'b0,1'b1,1'b1,2'd0,1'b0,32'h2000},
        '{1'b1,1'b1,32'h3000, 1'b1,1'b0,2'd0, 5'd1,5'd2,5'd3,5'd4,  32'h3008,32'h8000, 1'b0,1'b0,1'b0,2'd2,1'b0,32'h3008},
        '{1'b1,1'b0,32'h3008, 1'b0,1'b0,2'd0, 5'd1,5'd2,5'd3,5'd4,  32'h3008,32'h8000, 1'b1,1'b1,1'b0,2'd0,1'b0,32'h3008},
        '{1'b1,1'b1,32'h4000, 1'b1,1'b0,2'd0, 5'd1,5'd2,5'd3,5'd31, 32'h9990,32'h4000, 1'b1,1'b1,1'b0,2'd0,1'b0,32'h4000},
        '{1'b0,1'b0,32'h0,    1'b1,1'b0,2'd0, 5'd1,5'd2,5'd3,5'd31, 32'h9990,32'h4004, 1'b0,1'b0,1'b0,2'd3,1'b0,32'h0},
        '{1'b1,1'b1,32'h1000, 1'b1,1'b0,2'd1, 5'd2,5'd2,5'd3,5'd4,  32'h1000,32'h8000, 1'b0,1'b0,1'b0,2'd1,1'b0,32'h0},
        '{1'b0,1'b0,32'h0,    1'b1,1'b0,2'd2, 5'd3,5'd2,5'd3,5'd4,  32'h1000,32'h8000, 1'b0,1'b0,1'b0,2'd0,1'b0,32'h0},
        '{1'b0,1'b0,32'h0,    1'b1,1'b0,2'd0, 5'd1,5'd2,5'd3,5'd4,  32'h1000,32'h8000, 1'b1,1'b1,1'b0,2'd0,1'b0,32'h1000},
        '{1'b1,1'b1,32'h1000, 1'b1,1'b0,2'd0, 5'd2,5'd2,5'd3,5'd4,  32'h1000,32'h8000, 1'b1,1'b1,1'b0,2'd0,1'b1,32'h1000},
        '{1'b1,1'b1,32'h5000, 1'b1,1'b0,2'd0, 5'd5,5'd2,5'd3,5'd5,  32'h1000,32'h8000, 1'b1,1'b1,1'b0,2'd0,1'b0,32'h5000},
        '{1'b1,1'b1,32'h1000, 1'b1,1'b0,2'd1, 5'd6,5'd2,5'd3,5'd6,  32'h1000,32'h8000, 1'b0,1'b0,1'b0,2'd1,1'b0,32'h0},
        '{1'b1,1'b0,32'h1000, 1'b0,1'b0,2'd0, 5'd31,5'd2,5'd3,5'd31,32'h2000,32'h1000, 1'b1,1'b1,1'b0,2'd0,1'b0,32'h1000}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:  return "R3 R4 R1";
            1:  return "R9 R10";
            2:  return "R4 R1";
            3:  return "R9";
            4:  return "R8";
            5:  return "R8 R1";
            6:  return "R5";
            7:  return "R5";
            8:  return "R6";
            9:  return "R6";
            10: return "R6 R10";
            11: return "R6";
            12: return "R7";
            13: return "R7";
            default: return "R5 R2";
        endcase
    endfunction

    function automatic logic [127:0] exp_data(input logic sz, input logic be, input logic arb);
        if (arb) return sz ? ARB_D : {64'd0, ARB_D[63:0]};
        if (sz)  return be ? {RT_V, RT2_V} : {RT2_V, RT_V};
        return be ? {64'd0, RT_V[31:0], RT2_V[31:0]} : {64'd0, RT2_V[31:0], RT_V[31:0]};
    endfunction

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        arm_valid = 1'b0; arm_addr = '0; arm_wide = 1'b0;
        req_valid = 1'b0; req_wide = 1'b0; big_endian = 1'b0; ovl_policy = 2'd0;
        req_rs = 5'd1; req_rt = 5'd2; req_rt2 = 5'd3; req_rn = 5'd4;
        rn_val = '0; sp_val = '0;
    endtask

    task automatic arm(input logic [63:0] a, input logic w);
        @(negedge clk);
        arm_valid = 1'b1; arm_addr = a; arm_wide = w;
        @(negedge clk);
        arm_valid = 1'b0;
    endtask

    task automatic issue(input logic sz, input logic be, input logic [1:0] pol,
                         input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rt2,
                         input logic [4:0] rn, input logic [63:0] base, input logic [63:0] sp);
        @(negedge clk);
        req_valid = 1'b1; req_wide = sz; big_endian = be; ovl_policy = pol;
        req_rs = rs; req_rt = rt; req_rt2 = rt2; req_rn = rn; rn_val = base; sp_val = sp;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state, R11
        chk(res_valid == 1'b0 && wr_en == 1'b0 && st_wen == 1'b0, "R11 reset",
            {125'd0, res_valid, wr_en, st_wen}, 128'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            if (v.arm) arm({32'd0, v.arm_a}, v.arm_sz);
            issue(v.sz, v.be, v.pol, v.rs, v.rt, v.rt2, v.rn, {32'd0, v.base}, {32'd0, v.sp});
            // result registered at the edge that captured the request; sampled here
            chk(res_valid == 1'b1, {vec_tag(i), " R11 valid"}, {127'd0, res_valid}, 128'd1);
            chk(wr_en == v.e_wr, {vec_tag(i), " wr_en"}, {127'd0, wr_en}, {127'd0, v.e_wr});
            chk(st_wen == v.e_st, {vec_tag(i), " st_wen"}, {127'd0, st_wen}, {127'd0, v.e_st});
            chk(fault == v.e_flt, {vec_tag(i), " fault"}, {126'd0, fault}, {126'd0, v.e_flt});
            if (v.e_st)
                chk(st_data == {31'd0, v.e_stat} && st_idx == v.rs, {vec_tag(i), " R2 status"},
                    {91'd0, st_idx, st_data}, {91'd0, v.rs, 31'd0, v.e_stat});
            if (v.e_wr) begin
                chk(wr_addr == {32'd0, v.e_addr} && wr_wide == v.sz, {vec_tag(i), " R1 addr/size"},
                    {63'd0, wr_wide, wr_addr}, {63'd0, v.sz, 32'd0, v.e_addr});
                chk(wr_data == exp_data(v.sz, v.be, v.e_arb), {vec_tag(i), " data"},
                    wr_data, exp_data(v.sz, v.be, v.e_arb));
            end
        end

        // R11: no request, no result
        @(negedge clk);
        chk(res_valid == 1'b0 && st_wen == 1'b0, "R11 idle", {126'd0, res_valid, st_wen}, 128'd0);

        // R10: reset clears an armed monitor
        arm(64'h1000, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        issue(1'b1, 1'b0, 2'd0, 5'd1, 5'd2, 5'd3, 5'd4, 64'h1000, 64'h8000);
        chk(st_wen && st_data == 32'd1 && !wr_en, "R10 reset clears monitor",
            {127'd0, wr_en}, 128'd0);

        // R10: arm in the same cycle as a consuming request wins
        arm(64'h1000, 1'b1);
        @(negedge clk);
        req_valid = 1'b1; req_wide = 1'b1; big_endian = 1'b0; ovl_policy = 2'd0;
        req_rs = 5'd1; req_rt = 5'd2; req_rt2 = 5'd3; req_rn = 5'd4; rn_val = 64'h1000;
        arm_valid = 1'b1; arm_addr = 64'h6000; arm_wide = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; arm_valid = 1'b0;
        chk(wr_en && st_data == 32'd0, "R10 old state used", {127'd0, wr_en}, 128'd1);
        issue(1'b1, 1'b0, 2'd0, 5'd1, 5'd2, 5'd3, 5'd4, 64'h6000, 64'h8000);
        chk(wr_en && wr_addr == 64'h6000, "R10 concurrent arm kept", {64'd0, wr_addr}, 128'h6000);

        // R9: address mismatch with valid monitor
        arm(64'h7000, 1'b1);
        issue(1'b1, 1'b0, 2'd0, 5'd1, 5'd2, 5'd3, 5'd4, 64'h7010, 64'h8000);
        chk(!wr_en && st_data == 32'd1, "R9 address mismatch", {127'd0, wr_en}, 128'd0);

        // R8: misaligned with monitor empty still faults
        issue(1'b0, 1'b0, 2'd0, 5'd1, 5'd2, 5'd3, 5'd4, 64'h7004, 64'h8000);
        chk(fault == 2'd2 && !st_wen, "R8 fault on failing monitor", {126'd0, fault}, 128'd2);

        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule